// File: doc/BRIEF.md
# Exception Vector Selector

This block sits between instruction decode and the exception sequencer of a processor core. Each cycle it looks at several sources and picks the most urgent exception. The sources are the opword being issued, the floating-point enable bit, the presence straps of the optional execution units, the hardware breakpoint trigger pulses and a reset request. It then presents the chosen 8-bit vector number on a registered output. The vector stays there until the sequencer acknowledges it.

The opword check works on the top nibble. In the line-A space (1010), opwords of the multiply-accumulate class are defined and all others trap. In the line-F space (1111), floating-point opwords, a small always-present system class, and undefined opwords are told apart.

Breakpoint exceptions get their vector from the breakpoint type, with no acknowledge cycle. A debug exception also raises a flag that tells the sequencer to leave the status register's master-state and interrupt-mask fields alone. In two-level trigger mode the first event only arms the trigger. The second event fires it, and its own type chooses the vector. After hardware reset is released, the block presents the reset vector once a fixed settling delay has passed.

Top module: `exc_vector_select`

## Requirements
- R1: While rst_n is low, exc_valid is 0. After rst_n goes high, exc_valid stays 0 for POR_DELAY (default 16) clock edges. On the next edge it rises with vector 0 and exc_keep_sr_mi 0.
- R2: An issued opword with bits 15..12 = 1010 and bit 8 = 1 gives vector 10 on the next edge. With bit 8 = 0 it is a multiply-accumulate opword and raises nothing when unit_present[0] = 1.
- R3: A multiply-accumulate opword (bits 15..12 = 1010, bit 8 = 0) gives vector 97 (0x61) when unit_present[0] = 0.
- R4: A floating-point opword (bits 15..9 = 1111001) gives vector 97 when unit_present[1] = 0. It gives vector 11 when the unit is present but fpu_en = 0, and nothing when the unit is present and enabled.
- R5: Any other opword with bits 15..12 = 1111 gives vector 11, except bits 15..8 = 0xF4, which raises nothing. Opwords outside the 1010 and 1111 spaces raise nothing.
- R6: With bkpt_two_level = 0, a pulse on bkpt_pc gives vector 13 and a pulse on bkpt_addr gives vector 12. If both pulse in the same cycle, the vector is 13. exc_keep_sr_mi is 1 exactly when a breakpoint vector (12 or 13) is presented.
- R7: With bkpt_two_level = 1, the first breakpoint event raises nothing and arms the trigger. The next event raises the vector of that second event's type and disarms.
- R8: Requests arriving in the same cycle are ranked reset, then breakpoint, then unavailable-unit (97), then line-A/line-F. A breakpoint that loses to reset is kept and delivered after the reset vector is acknowledged.
- R9: A presented vector holds exc_valid and exc_vector stable until an edge with exc_ack = 1. An opword issued while a vector is held and not being acknowledged has no effect.
- R10: Breakpoint events that fire while a vector is held are kept pending and delivered after the acknowledge. The type of the most recent event selects the vector.
- R11: rst_req = 1 at an edge makes exc_vector 0 with exc_valid 1 after that edge, replacing any held lower-priority vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An opword is being issued this cycle |
| opword | input | 16 | First word of the issued instruction |
| fpu_en | input | 1 | Floating-point enable control bit |
| unit_present | input | 2 | Optional unit straps: bit 0 multiply-accumulate, bit 1 floating point |
| bkpt_pc | input | 1 | Program-counter breakpoint trigger pulse |
| bkpt_addr | input | 1 | Address/data breakpoint trigger pulse |
| bkpt_two_level | input | 1 | Two-level trigger mode select |
| rst_req | input | 1 | Reset exception request |
| exc_ack | input | 1 | Sequencer has taken the presented vector |
| exc_valid | output | 1 | An exception vector is presented |
| exc_vector | output | 8 | Presented vector number |
| exc_keep_sr_mi | output | 1 | Status register master-state and interrupt-mask must stay unchanged |

## Verification
The opword path is driven with one sample from each decode class: undefined line-A, multiply-accumulate with its unit present and absent, floating point in its three present/enabled states, undefined line-F, the defined 0xF4 class, and ordinary opwords. These samples separate a wrong nibble compare, a wrong class mask and a wrong precedence between an absent unit and a disabled one. Breakpoint patterns cover each type alone, both types together, and two-level sequences in both orders, which exposes a vector taken from the arming event. Collision patterns combine a breakpoint with a faulting opword, reset with both, breakpoints arriving during a hold, and reset arriving during a hold. These check the ranking, the retention of lost debug events and reset preemption.

// File: rtl/exc_vec_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the exception vector selector.
// Assumes an 8-bit vector space and a 16-bit opword.
package exc_vec_pkg;
    localparam int VEC_W     = 8;
    localparam int OP_W      = 16;
    localparam int NUM_UNITS = 2;
    localparam int UNIT_MAC  = 0;
    localparam int UNIT_FPU  = 1;

    typedef logic [VEC_W-1:0] vec_t;

    localparam vec_t VEC_RESET  = 8'd0;
    localparam vec_t VEC_LINE_A = 8'd10;
    localparam vec_t VEC_LINE_F = 8'd11;
    localparam vec_t VEC_DBG_AD = 8'd12;
    localparam vec_t VEC_DBG_PC = 8'd13;
    localparam vec_t VEC_UNSUPP = 8'h61;

    typedef enum logic [1:0] {
        DEC_NONE,
        DEC_LINE_A,
        DEC_LINE_F,
        DEC_UNSUPP
    } dec_kind_e;
endpackage

// File: rtl/opclass_decode.sv
`timescale 1ns/1ps
// Module: opclass_decode
// Classifies an issued opword into no exception, line-A, line-F or
// unavailable optional unit. Purely combinational.
// Assumes the opword is stable while op_valid is high.
module opclass_decode
    import exc_vec_pkg::*;
#(
    parameter logic [OP_W-1:0] MAC_MASK  = 16'hF100,
    parameter logic [OP_W-1:0] MAC_MATCH = 16'hA000,
    parameter logic [OP_W-1:0] FP_MASK   = 16'hFE00,
    parameter logic [OP_W-1:0] FP_MATCH  = 16'hF200,
    parameter logic [OP_W-1:0] SYS_MASK  = 16'hFF00,
    parameter logic [OP_W-1:0] SYS_MATCH = 16'hF400
) (
    input  logic                 op_valid,
    input  logic [OP_W-1:0]      opword,
    input  logic                 fpu_en,
    input  logic [NUM_UNITS-1:0] unit_present,
    output dec_kind_e            dec_kind
);
    localparam int NIB_LSB = OP_W - 4;

    logic [3:0] top_nib;
    logic       in_line_a;
    logic       in_line_f;
    logic       is_mac;
    logic       is_fp;
    logic       is_sys;

    // Extract the opcode space and the defined classes within it.
    always_comb begin
        top_nib   = opword[OP_W-1:NIB_LSB];
        in_line_a = (top_nib == 4'hA);
        in_line_f = (top_nib == 4'hF);
        is_mac    = in_line_a && ((opword & MAC_MASK) == MAC_MATCH);
        is_fp     = in_line_f && ((opword & FP_MASK) == FP_MATCH);
        is_sys    = in_line_f && !is_fp && ((opword & SYS_MASK) == SYS_MATCH);
    end

    // Resolve the class into one decode outcome.
    always_comb begin
        dec_kind = DEC_NONE;
        if (op_valid) begin
            if (is_mac) begin
                dec_kind = unit_present[UNIT_MAC] ? DEC_NONE : DEC_UNSUPP;
            end else if (in_line_a) begin
                dec_kind = DEC_LINE_A;
            end else if (is_fp) begin
                if (!unit_present[UNIT_FPU]) begin
                    dec_kind = DEC_UNSUPP;
                end else if (!fpu_en) begin
                    dec_kind = DEC_LINE_F;
                end
            end else if (in_line_f && !is_sys) begin
                dec_kind = DEC_LINE_F;
            end
        end
    end
endmodule

// File: rtl/bkpt_tracker.sv
`timescale 1ns/1ps
// Module: bkpt_tracker
// Turns breakpoint trigger pulses into a debug request carrying the
// breakpoint type. Handles two-level arming and keeps a fired request
// pending until the arbiter takes it; a newer event overwrites the type.
// Assumes trigger inputs are single-cycle pulses.
module bkpt_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic bkpt_pc,
    input  logic bkpt_addr,
    input  logic two_level,
    input  logic taken,
    output logic dbg_req,
    output logic dbg_is_pc
);
    logic armed;
    logic pend;
    logic pend_pc;
    logic any_evt;
    logic fire_now;
    logic arm_now;

    // Decide whether this cycle's event arms or fires the trigger.
    always_comb begin
        any_evt   = bkpt_pc || bkpt_addr;
        fire_now  = any_evt && (!two_level || armed);
        arm_now   = any_evt && two_level && !armed;
        dbg_req   = fire_now || pend;
        dbg_is_pc = fire_now ? bkpt_pc : pend_pc;
    end

    // Track the first level of a two-level trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (!two_level) begin
            armed <= 1'b0;
        end else if (arm_now) begin
            armed <= 1'b1;
        end else if (fire_now) begin
            armed <= 1'b0;
        end
    end

    // Hold a fired request that the arbiter could not take yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pend_pc <= 1'b0;
        end else if (taken) begin
            pend    <= 1'b0;
            pend_pc <= 1'b0;
        end else if (fire_now) begin
            pend    <= 1'b1;
            pend_pc <= bkpt_pc;
        end
    end
endmodule

// File: rtl/por_delay.sv
`timescale 1ns/1ps
// Module: por_delay
// Raises a reset exception request DELAY edges after reset release and
// drops it once the arbiter has taken it. DELAY = 0 requests at once.
// Assumes taken is only asserted while por_req is high.
module por_delay #(
    parameter int DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic taken,
    output logic por_req
);
    logic done;

    // Record that the power-on reset vector has been delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (taken) begin
            done <= 1'b1;
        end
    end

    generate
        if (DELAY > 0) begin : g_wait
            localparam int CW = $clog2(DELAY + 1);
            localparam logic [CW-1:0] LAST = CW'(DELAY);
            logic [CW-1:0] cnt;

            // Count settling edges after reset release.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (cnt != LAST) begin
                    cnt <= cnt + 1'b1;
                end
            end

            // Request once the count is complete.
            always_comb por_req = (cnt == LAST) && !done;
        end else begin : g_now
            // Request immediately after reset release.
            always_comb por_req = !done;
        end
    endgenerate
endmodule

// File: rtl/vector_arbiter.sv
`timescale 1ns/1ps
// Module: vector_arbiter
// Ranks reset, debug and decode requests and registers the winner.
// The output holds until acknowledged, except that reset replaces any
// held non-reset vector.
// Assumes dec_kind is only meaningful when an opword is issued.
module vector_arbiter
    import exc_vec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rst_req,
    input  logic      por_req,
    input  logic      dbg_req,
    input  logic      dbg_is_pc,
    input  dec_kind_e dec_kind,
    input  logic      exc_ack,
    output logic      exc_valid,
    output vec_t      exc_vector,
    output logic      exc_keep,
    output logic      dbg_taken,
    output logic      reset_taken
);
    logic accept;
    logic held_reset;
    logic load_reset;
    logic nxt_valid;
    vec_t nxt_vector;
    logic nxt_keep;

    // Work out whether the output register may take a new vector.
    always_comb begin
        accept      = !exc_valid || exc_ack;
        held_reset  = exc_valid && (exc_vector == VEC_RESET);
        load_reset  = (rst_req || por_req) && (accept || !held_reset);
        reset_taken = load_reset;
        dbg_taken   = !load_reset && accept && dbg_req;
    end

    // Select the next register contents by fixed priority.
    always_comb begin
        nxt_valid  = exc_valid;
        nxt_vector = exc_vector;
        nxt_keep   = exc_keep;
        if (load_reset) begin
            nxt_valid  = 1'b1;
            nxt_vector = VEC_RESET;
            nxt_keep   = 1'b0;
        end else if (accept) begin
            nxt_keep = 1'b0;
            if (dbg_req) begin
                nxt_valid  = 1'b1;
                nxt_vector = dbg_is_pc ? VEC_DBG_PC : VEC_DBG_AD;
                nxt_keep   = 1'b1;
            end else begin
                unique case (dec_kind)
                    DEC_UNSUPP: begin
                        nxt_valid  = 1'b1;
                        nxt_vector = VEC_UNSUPP;
                    end
                    DEC_LINE_A: begin
                        nxt_valid  = 1'b1;
                        nxt_vector = VEC_LINE_A;
                    end
                    DEC_LINE_F: begin
                        nxt_valid  = 1'b1;
                        nxt_vector = VEC_LINE_F;
                    end
                    default: begin
                        nxt_valid = 1'b0;
                    end
                endcase
            end
        end
    end

    // Register the presented exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid  <= 1'b0;
            exc_vector <= VEC_RESET;
            exc_keep   <= 1'b0;
        end else begin
            exc_valid  <= nxt_valid;
            exc_vector <= nxt_vector;
            exc_keep   <= nxt_keep;
        end
    end
endmodule

// File: rtl/exc_vector_select.sv
`timescale 1ns/1ps
// Module: exc_vector_select (top)
// Exception vector selector: decodes the issued opword, tracks
// breakpoint triggers, sequences the power-on reset request and
// presents one registered vector at a time to the exception sequencer.
// Assumes the sequencer acknowledges with a single-cycle exc_ack.
module exc_vector_select
    import exc_vec_pkg::*;
#(
    parameter int POR_DELAY = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [15:0] opword,
    input  logic        fpu_en,
    input  logic [1:0]  unit_present,
    input  logic        bkpt_pc,
    input  logic        bkpt_addr,
    input  logic        bkpt_two_level,
    input  logic        rst_req,
    input  logic        exc_ack,
    output logic        exc_valid,
    output logic [7:0]  exc_vector,
    output logic        exc_keep_sr_mi
);
    dec_kind_e dec_kind;
    logic      dbg_req;
    logic      dbg_is_pc;
    logic      dbg_taken;
    logic      por_req;
    logic      reset_taken;
    logic      por_taken;

    // Only credit the power-on request when it is the one pending.
    always_comb por_taken = reset_taken && por_req;

    opclass_decode u_decode (
        .op_valid     (op_valid),
        .opword       (opword),
        .fpu_en       (fpu_en),
        .unit_present (unit_present),
        .dec_kind     (dec_kind)
    );

    bkpt_tracker u_bkpt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bkpt_pc   (bkpt_pc),
        .bkpt_addr (bkpt_addr),
        .two_level (bkpt_two_level),
        .taken     (dbg_taken),
        .dbg_req   (dbg_req),
        .dbg_is_pc (dbg_is_pc)
    );

    por_delay #(.DELAY(POR_DELAY)) u_por (
        .clk     (clk),
        .rst_n   (rst_n),
        .taken   (por_taken),
        .por_req (por_req)
    );

    vector_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_req     (rst_req),
        .por_req     (por_req),
        .dbg_req     (dbg_req),
        .dbg_is_pc   (dbg_is_pc),
        .dec_kind    (dec_kind),
        .exc_ack     (exc_ack),
        .exc_valid   (exc_valid),
        .exc_vector  (exc_vector),
        .exc_keep    (exc_keep_sr_mi),
        .dbg_taken   (dbg_taken),
        .reset_taken (reset_taken)
    );
endmodule

// File: rtl/exc_vector_select_chk.sv
`timescale 1ns/1ps
// Module: exc_vector_select_chk
// Property checker for the exception vector selector, bound to the top.
// Assumes por_req is the power-on request from inside the top.
module exc_vector_select_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [15:0] opword,
    input logic [1:0]  unit_present,
    input logic        bkpt_pc,
    input logic        bkpt_addr,
    input logic        rst_req,
    input logic        exc_ack,
    input logic        exc_valid,
    input logic [7:0]  exc_vector,
    input logic        exc_keep_sr_mi,
    input logic        por_req
);
    // R9
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && !exc_ack && !rst_req |=> exc_valid && $stable(exc_vector));

    // R6
    keep_only_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && exc_keep_sr_mi |-> (exc_vector == 8'd12) || (exc_vector == 8'd13));

    // R6
    debug_sets_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && ((exc_vector == 8'd12) || (exc_vector == 8'd13)) |-> exc_keep_sr_mi);

    // R11
    reset_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> exc_valid && (exc_vector == 8'd0));

    // R2
    line_a_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid && op_valid && (opword[15:12] == 4'hA) && opword[8]
        && !rst_req && !por_req && !bkpt_pc && !bkpt_addr
        |=> exc_valid && (exc_vector == 8'd10));

    // R3
    mac_absent_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid && op_valid && (opword[15:12] == 4'hA) && !opword[8]
        && !unit_present[0] && !rst_req && !por_req && !bkpt_pc && !bkpt_addr
        |=> exc_valid && (exc_vector == 8'h61));
endmodule

bind exc_vector_select exc_vector_select_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .opword         (opword),
    .unit_present   (unit_present),
    .bkpt_pc        (bkpt_pc),
    .bkpt_addr      (bkpt_addr),
    .rst_req        (rst_req),
    .exc_ack        (exc_ack),
    .exc_valid      (exc_valid),
    .exc_vector     (exc_vector),
    .exc_keep_sr_mi (exc_keep_sr_mi),
    .por_req        (por_req)
);

// File: tb/exc_vector_select_test.sv
`timescale 1ns/1ps
module exc_vector_select_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] opword = 16'h0000;
    logic        fpu_en = 1'b1;
    logic [1:0]  unit_present = 2'b11;
    logic        bkpt_pc = 1'b0;
    logic        bkpt_addr = 1'b0;
    logic        bkpt_two_level = 1'b0;
    logic        rst_req = 1'b0;
    logic        exc_ack = 1'b0;
    logic        exc_valid;
    logic [7:0]  exc_vector;
    logic        exc_keep_sr_mi;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #2.5 clk = ~clk;

    exc_vector_select #(.POR_DELAY(16)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid       (op_valid),
        .opword         (opword),
        .fpu_en         (fpu_en),
        .unit_present   (unit_present),
        .bkpt_pc        (bkpt_pc),
        .bkpt_addr      (bkpt_addr),
        .bkpt_two_level (bkpt_two_level),
        .rst_req        (rst_req),
        .exc_ack        (exc_ack),
        .exc_valid      (exc_valid),
        .exc_vector     (exc_vector),
        .exc_keep_sr_mi (exc_keep_sr_mi)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs; vector and keep are only checked when valid.
    task automatic expect_out(input string req, input bit v, input int vec, input bit keep);
        chk(exc_valid == v, req, "exc_valid", exc_valid, v);
        if (v) begin
            chk(exc_vector == vec, req, "exc_vector", exc_vector, vec);
            chk(exc_keep_sr_mi == keep, req, "exc_keep_sr_mi", exc_keep_sr_mi, keep);
        end
    endtask

    // All tasks start and end right after a falling edge.
    task automatic issue_op(input logic [15:0] op);
        op_valid = 1'b1;
        opword   = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_ack();
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
    endtask

    task automatic pulse_bkpt(input bit pc, input bit ad);
        bkpt_pc   = pc;
        bkpt_addr = ad;
        @(negedge clk);
        bkpt_pc   = 1'b0;
        bkpt_addr = 1'b0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic t_power_on();
        repeat (3) @(negedge clk);
        expect_out("R1", 0, 0, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk(exc_valid == 1'b0, "R1", "valid during delay", exc_valid, 0);
        end
        @(negedge clk);
        expect_out("R1", 1, 0, 0);
        do_ack();
        expect_out("R1", 0, 0, 0);
    endtask

    task automatic t_line_a();
        issue_op(16'hA100);
        expect_out("R2", 1, 10, 0);
        do_ack();
        expect_out("R2", 0, 0, 0);
        issue_op(16'hA0C4);
        expect_out("R2", 0, 0, 0);
    endtask

    task automatic t_mac_absent();
        unit_present = 2'b10;
        issue_op(16'hA000);
        expect_out("R3", 1, 97, 0);
        do_ack();
        unit_present = 2'b11;
        expect_out("R3", 0, 0, 0);
    endtask

    task automatic t_fpu();
        issue_op(16'hF200);
        expect_out("R4", 0, 0, 0);
        fpu_en = 1'b0;
        issue_op(16'hF380);
        expect_out("R4", 1, 11, 0);
        do_ack();
        fpu_en = 1'b1;
        unit_present = 2'b01;
        issue_op(16'hF200);
        expect_out("R4", 1, 97, 0);
        do_ack();
        unit_present = 2'b11;
        expect_out("R4", 0, 0, 0);
    endtask

    task automatic t_line_f();
        issue_op(16'hF000);
        expect_out("R5", 1, 11, 0);
        do_ack();
        issue_op(16'hF4A8);
        expect_out("R5", 0, 0, 0);
        issue_op(16'hF800);
        expect_out("R5", 1, 11, 0);
        do_ack();
        issue_op(16'h4E71);
        expect_out("R5", 0, 0, 0);
        issue_op(16'hB000);
        expect_out("R5", 0, 0, 0);
    endtask

    task automatic t_debug_single();
        pulse_bkpt(1, 0);
        expect_out("R6", 1, 13, 1);
        do_ack();
        pulse_bkpt(0, 1);
        expect_out("R6", 1, 12, 1);
        do_ack();
        pulse_bkpt(1, 1);
        expect_out("R6", 1, 13, 1);
        do_ack();
        expect_out("R6", 0, 0, 0);
    endtask

    task automatic t_debug_two_level();
        bkpt_two_level = 1'b1;
        pulse_bkpt(0, 1);
        expect_out("R7", 0, 0, 0);
        pulse_bkpt(1, 0);
        expect_out("R7", 1, 13, 1);
        do_ack();
        pulse_bkpt(1, 0);
        expect_out("R7", 0, 0, 0);
        pulse_bkpt(0, 1);
        expect_out("R7", 1, 12, 1);
        do_ack();
        bkpt_two_level = 1'b0;
        expect_out("R7", 0, 0, 0);
    endtask

    task automatic t_priority();
        op_valid = 1'b1; opword = 16'hA100; bkpt_addr = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; bkpt_addr = 1'b0;
        expect_out("R8", 1, 12, 1);
        do_ack();
        expect_out("R8", 0, 0, 0);
        op_valid = 1'b1; opword = 16'hF000; bkpt_pc = 1'b1; rst_req = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; bkpt_pc = 1'b0; rst_req = 1'b0;
        expect_out("R8", 1, 0, 0);
        do_ack();
        expect_out("R8", 1, 13, 1);
        do_ack();
        expect_out("R8", 0, 0, 0);
    endtask

    task automatic t_hold();
        issue_op(16'hA100);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            expect_out("R9", 1, 10, 0);
        end
        issue_op(16'hF000);
        expect_out("R9", 1, 10, 0);
        do_ack();
        expect_out("R9", 0, 0, 0);
        @(negedge clk);
        expect_out("R9", 0, 0, 0);
    endtask

    task automatic t_pending_debug();
        issue_op(16'hA100);
        pulse_bkpt(0, 1);
        expect_out("R10", 1, 10, 0);
        pulse_bkpt(1, 0);
        expect_out("R10", 1, 10, 0);
        do_ack();
        expect_out("R10", 1, 13, 1);
        do_ack();
        expect_out("R10", 0, 0, 0);
    endtask

    task automatic t_reset_preempt();
        issue_op(16'hF000);
        expect_out("R11", 1, 11, 0);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        expect_out("R11", 1, 0, 0);
        do_ack();
        expect_out("R11", 0, 0, 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        @(negedge clk);
        t_power_on();
        t_line_a();
        t_mac_absent();
        t_fpu();
        t_line_f();
        t_debug_single();
        t_debug_two_level();
        t_priority();
        t_hold();
        t_pending_debug();
        t_reset_preempt();
        report();
    end
endmodule